// File: doc/BRIEF.md
# Bilateral Weight Engine (3x3, table-driven)

This block produces one edge-preserving smoothed pixel from a 3x3 neighbourhood of 8-bit grey pixels. Each of the eight outer pixels gets a weight that combines its distance from the centre with how far its value is from the centre value. The weight is not evaluated at run time. It is read from a combined weight table that already holds the product of the distance weight and the intensity weight. The table is addressed by the tap's geometric class and the absolute intensity difference. The centre pixel always weighs full scale. The engine forms the weighted pixel sum and the weight sum, then divides them in a pipelined restoring divider. The result is rounded to nearest.

A line-buffer front end presents one complete window per clock with a valid strobe. One filtered pixel with a valid strobe comes out a fixed number of cycles later. The table contents come from parameters, as Gaussian weights for a given spatial and range sigma. They can also be overwritten entry by entry through a write port while the pipeline is idle.

Top module: `bilat_weight_engine`

## Requirements
- R1: A window sampled with `in_valid` high on a clock edge produces `out_valid` high exactly 13 clock edges later. A new window is accepted on every clock, so back-to-back windows give back-to-back results.
- R2: `out_pix` equals floor((2*S + W) / (2*W)), saturated at 255. Here S = sum of w_k*p_k over the nine taps and W = sum of w_k. This is the weighted mean rounded to nearest, with halves rounded up.
- R3: The centre tap weight is always 255. A table write with class code 0 (centre) or 3 (unused) changes no result.
- R4: Tap k = 3*row + col carries pixel `in_win[8k+7:8k]`. Tap 4 is the centre. Taps 1, 3, 5 and 7 use class 1 (edge). Taps 0, 2, 6 and 8 use class 2 (corner). Each outer tap's weight is the class-table entry at |p_k - p_4|.
- R5: A write with `tbl_we` high stores `tbl_wdata` at class `tbl_waddr[9:8]` and difference `tbl_waddr[7:0]`. It applies to every window sampled on later clock edges.
- R6: After configuration the class-c entry for difference d is round(255 * exp(-s/(2*SIGMA_S^2)) * exp(-d^2/(2*SIGMA_R^2))). Here s = 1 for edge and s = 2 for corner, with SIGMA_S = SIGMA_S_MILLI/1000.
- R7: Every result lies between the smallest and the largest pixel of its window. A window of nine equal pixels returns that value.
- R8: During and after reset, `out_valid` is 0 and `out_pix` is 0. `out_pix` holds its value on every cycle where `out_valid` is low.
- R9: When all outer weights read as zero, the result equals the centre pixel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Window on `in_win` is valid this cycle |
| in_win | input | 72 | Nine pixels, tap k in bits [8k+7:8k] |
| out_valid | output | 1 | `out_pix` carries a new result |
| out_pix | output | 8 | Filtered pixel |
| tbl_we | input | 1 | Weight table write strobe |
| tbl_waddr | input | 10 | {class[1:0], difference[7:0]} |
| tbl_wdata | input | 8 | Weight, Q0.8 unsigned |

## Verification
The bench targets four families of corner cases.

- Flat windows at 0, mid-grey and 255. An accumulator or divider that loses a bit drifts off the input value at full scale.
- Step edges and extreme 0/255 mixes. A wrong absolute-difference sign or a swapped tap class picks the wrong table entry, and the mean leaks across the edge.
- Tables zeroed through the write port, including attempted writes to the centre class. A design that let the centre weight be overwritten would divide by zero or return garbage instead of the centre pixel.
- Random gaps in the valid strobe, which expose a latency that is off by one and an output that does not hold between results.

// File: rtl/bwe_pkg.sv
package bwe_pkg;

  localparam int NTAP    = 9;
  localparam int CTR_TAP = 4;
  localparam int CLS_W   = 2;

  typedef enum logic [1:0] {
    CLS_CTR    = 2'd0,
    CLS_EDGE   = 2'd1,
    CLS_CORNER = 2'd2
  } tap_cls_e;

  function automatic tap_cls_e tap_class(input int k);
    if (k == CTR_TAP)   return CLS_CTR;
    else if (k % 2 == 0) return CLS_CORNER;
    else                 return CLS_EDGE;
  endfunction

  function automatic int class_dist2(input tap_cls_e c);
    case (c)
      CLS_EDGE:   return 1;
      CLS_CORNER: return 2;
      default:    return 0;
    endcase
  endfunction

  // Gaussian spatial x range product, scaled to wmax and rounded
  function automatic int default_weight(input int d2, input int diff, input int wmax,
                                        input int sig_s_milli, input int sig_r);
    real ss, sr, es, er;
    int  v;
    ss = real'(sig_s_milli) / 1000.0;
    sr = real'(sig_r);
    es = $exp(-real'(d2) / (2.0 * ss * ss));
    er = $exp(-real'(diff * diff) / (2.0 * sr * sr));
    v  = $rtoi(real'(wmax) * es * er + 0.5);
    if (v > wmax) v = wmax;
    return v;
  endfunction

endpackage

// File: rtl/bwe_wtab.sv
module bwe_wtab #(
  parameter int PIX_W         = 8,
  parameter int WGT_W         = 8,
  parameter int CLASS_D2      = 1,
  parameter int SIGMA_S_MILLI = 1000,
  parameter int SIGMA_R       = 20
) (
  input  logic             clk,
  input  logic [PIX_W-1:0] rd_addr,
  output logic [WGT_W-1:0] rd_data,
  input  logic             wr_en,
  input  logic [PIX_W-1:0] wr_addr,
  input  logic [WGT_W-1:0] wr_data
);
  localparam int DEPTH = 1 << PIX_W;
  localparam int WMAX  = (1 << WGT_W) - 1;

  logic [WGT_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++)
      mem[i] = WGT_W'(bwe_pkg::default_weight(CLASS_D2, i, WMAX, SIGMA_S_MILLI, SIGMA_R));
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/bwe_accum.sv
module bwe_accum #(
  parameter int PIX_W = 8,
  parameter int WGT_W = 8,
  parameter int NT    = 9,
  parameter int SUM_W = 20,
  parameter int DEN_W = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [NT*PIX_W-1:0]   pix,
  input  logic [NT*WGT_W-1:0]   wgt,
  output logic                  out_valid,
  output logic [SUM_W-1:0]      num,
  output logic [DEN_W-1:0]      den
);
  localparam int PW = PIX_W + WGT_W;

  logic [PW-1:0]    prod [NT];
  logic [WGT_W-1:0] wb   [NT];
  logic             vb;
  logic [SUM_W-1:0] num_c;
  logic [DEN_W-1:0] den_c;

  // stage B: one multiplier per tap
  always_ff @(posedge clk) begin
    for (int k = 0; k < NT; k++) begin
      prod[k] <= PW'(wgt[k*WGT_W +: WGT_W]) * PW'(pix[k*PIX_W +: PIX_W]);
      wb[k]   <= wgt[k*WGT_W +: WGT_W];
    end
    if (rst) vb <= 1'b0;
    else     vb <= in_valid;
  end

  always_comb begin
    num_c = '0;
    den_c = '0;
    for (int k = 0; k < NT; k++) begin
      num_c = num_c + SUM_W'(prod[k]);
      den_c = den_c + DEN_W'(wb[k]);
    end
  end

  // stage C: adder trees registered
  always_ff @(posedge clk) begin
    num <= num_c;
    den <= den_c;
    if (rst) out_valid <= 1'b0;
    else     out_valid <= vb;
  end
endmodule

// File: rtl/bwe_div.sv
module bwe_div #(
  parameter int NW = 21,
  parameter int DW = 13,
  parameter int QW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [NW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          out_valid,
  output logic [QW-1:0] quo
);
  localparam int EW = NW + QW + DW;

  logic [NW-1:0] rem [QW+1];
  logic [DW-1:0] dv  [QW+1];
  logic [QW-1:0] q   [QW+1];
  logic          v   [QW+1];

  assign rem[0] = dividend;
  assign dv[0]  = divisor;
  assign q[0]   = '0;
  assign v[0]   = in_valid;

  // one quotient bit per stage, most significant first
  for (genvar s = 0; s < QW; s++) begin : g_stage
    localparam int B = QW - 1 - s;
    logic [EW-1:0] shifted;
    logic [EW-1:0] rem_ext;
    logic          take;
    assign shifted = EW'(dv[s]) << B;
    assign rem_ext = EW'(rem[s]);
    assign take    = rem_ext >= shifted;

    always_ff @(posedge clk) begin
      rem[s+1] <= take ? NW'(rem_ext - shifted) : rem[s];
      dv[s+1]  <= dv[s];
      q[s+1]   <= take ? (q[s] | QW'(1 << B)) : q[s];
      if (rst) v[s+1] <= 1'b0;
      else     v[s+1] <= v[s];
    end
  end

  assign out_valid = v[QW];
  assign quo       = q[QW];

  logic unused_tail;
  assign unused_tail = ^{rem[QW], dv[QW]};
endmodule

// File: rtl/bilat_weight_engine.sv
module bilat_weight_engine
  import bwe_pkg::*;
#(
  parameter int PIX_W         = 8,
  parameter int WGT_W         = 8,
  parameter int SIGMA_S_MILLI = 1000,
  parameter int SIGMA_R       = 20
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [NTAP*PIX_W-1:0]   in_win,
  output logic                    out_valid,
  output logic [PIX_W-1:0]        out_pix,
  input  logic                    tbl_we,
  input  logic [CLS_W+PIX_W-1:0]  tbl_waddr,
  input  logic [WGT_W-1:0]        tbl_wdata
);
  localparam int WMAX    = (1 << WGT_W) - 1;
  localparam int PMAX    = (1 << PIX_W) - 1;
  localparam int TAP_LOG = $clog2(NTAP);
  localparam int SUM_W   = PIX_W + WGT_W + TAP_LOG;
  localparam int DEN_W   = WGT_W + TAP_LOG;
  localparam int NW      = SUM_W + 1;
  localparam int DW      = DEN_W + 1;
  localparam int QW      = PIX_W + 1;
  localparam int LATENCY = QW + 4;

  // stage A: difference, table read
  logic [PIX_W-1:0]      px   [NTAP];
  logic [PIX_W-1:0]      adif [NTAP];
  logic [WGT_W-1:0]      w_a  [NTAP];
  logic [NTAP*WGT_W-1:0] w_vec;
  logic [NTAP*PIX_W-1:0] pix_a;
  logic                  va;
  logic [CLS_W-1:0]      wr_cls;

  assign wr_cls = tbl_waddr[PIX_W +: CLS_W];

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    assign px[k]   = in_win[k*PIX_W +: PIX_W];
    assign adif[k] = (px[k] > px[CTR_TAP]) ? px[k] - px[CTR_TAP] : px[CTR_TAP] - px[k];
    if (k == CTR_TAP) begin : g_ctr
      logic unused_ctr;
      assign unused_ctr = ^adif[k];
      assign w_a[k]     = WGT_W'(WMAX);
    end else begin : g_outer
      localparam tap_cls_e CLS = tap_class(k);
      bwe_wtab #(
        .PIX_W        (PIX_W),
        .WGT_W        (WGT_W),
        .CLASS_D2     (class_dist2(CLS)),
        .SIGMA_S_MILLI(SIGMA_S_MILLI),
        .SIGMA_R      (SIGMA_R)
      ) u_tab (
        .clk    (clk),
        .rd_addr(adif[k]),
        .rd_data(w_a[k]),
        .wr_en  (tbl_we && (wr_cls == CLS)),
        .wr_addr(tbl_waddr[PIX_W-1:0]),
        .wr_data(tbl_wdata)
      );
    end
    assign w_vec[k*WGT_W +: WGT_W] = w_a[k];
  end

  always_ff @(posedge clk) begin
    pix_a <= in_win;
    if (rst) va <= 1'b0;
    else     va <= in_valid;
  end

  // stages B, C: products and sums
  logic             vc;
  logic [SUM_W-1:0] num;
  logic [DEN_W-1:0] den;

  bwe_accum #(
    .PIX_W(PIX_W), .WGT_W(WGT_W), .NT(NTAP), .SUM_W(SUM_W), .DEN_W(DEN_W)
  ) u_acc (
    .clk      (clk),
    .rst      (rst),
    .in_valid (va),
    .pix      (pix_a),
    .wgt      (w_vec),
    .out_valid(vc),
    .num      (num),
    .den      (den)
  );

  // rounded division: (2S + W) / (2W)
  logic [NW-1:0] n_rnd;
  logic [DW-1:0] d_rnd;
  logic          vq;
  logic [QW-1:0] quo;

  assign n_rnd = {num, 1'b0} + NW'(den);
  assign d_rnd = {den, 1'b0};

  bwe_div #(.NW(NW), .DW(DW), .QW(QW)) u_div (
    .clk      (clk),
    .rst      (rst),
    .in_valid (vc),
    .dividend (n_rnd),
    .divisor  (d_rnd),
    .out_valid(vq),
    .quo      (quo)
  );

  // output register, saturating
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= vq;
      if (vq) out_pix <= (quo > QW'(PMAX)) ? PIX_W'(PMAX) : quo[PIX_W-1:0];
    end
  end
endmodule

// File: rtl/bwe_chk.sv
module bwe_chk #(
  parameter int PIX_W = 8,
  parameter int NT    = 9,
  parameter int LAT   = 13
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [NT*PIX_W-1:0] in_win,
  input logic                out_valid,
  input logic [PIX_W-1:0]    out_pix
);
  logic [PIX_W-1:0] mn_c, mx_c;
  logic             v_sh  [LAT];
  logic [PIX_W-1:0] mn_sh [LAT];
  logic [PIX_W-1:0] mx_sh [LAT];

  always_comb begin
    mn_c = in_win[PIX_W-1:0];
    mx_c = in_win[PIX_W-1:0];
    for (int k = 1; k < NT; k++) begin
      if (in_win[k*PIX_W +: PIX_W] < mn_c) mn_c = in_win[k*PIX_W +: PIX_W];
      if (in_win[k*PIX_W +: PIX_W] > mx_c) mx_c = in_win[k*PIX_W +: PIX_W];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LAT; i++) begin
      if (rst) v_sh[i] <= 1'b0;
      else     v_sh[i] <= (i == 0) ? in_valid : v_sh[i-1];
      mn_sh[i] <= (i == 0) ? mn_c : mn_sh[i-1];
      mx_sh[i] <= (i == 0) ? mx_c : mx_sh[i-1];
    end
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid == v_sh[LAT-1]);

  assert_bounds_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_pix >= mn_sh[LAT-1] && out_pix <= mx_sh[LAT-1]));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_pix));

  assert_reset_R8: assert property (@(posedge clk)
    rst |=> (!out_valid && out_pix == '0));
endmodule

bind bilat_weight_engine bwe_chk #(
  .PIX_W(PIX_W), .NT(bwe_pkg::NTAP), .LAT(LATENCY)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_win(in_win),
  .out_valid(out_valid), .out_pix(out_pix)
);

// File: tb/bilat_weight_engine_tb.sv
module bilat_weight_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [71:0] in_win = '0;
  logic        out_valid;
  logic [7:0]  out_pix;
  logic        tbl_we = 1'b0;
  logic [9:0]  tbl_waddr = '0;
  logic [7:0]  tbl_wdata = '0;

  int    checks = 0, bad = 0, cyc = 0;
  int    tab [3][256];
  int    exp_q[$], cyc_q[$];
  int    last_out = 0;
  bit    done = 1'b0;
  string tag = "R2 R4 R6";

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  bilat_weight_engine u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_win(in_win),
    .out_valid(out_valid), .out_pix(out_pix),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata)
  );

  task automatic check(input string t, input int got, input int expv);
    checks++;
    if (got != expv) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", t, got, expv);
    end
  endtask

  function automatic int gauss(input int d2, input int diff);
    real es, er;
    es = $exp(-real'(d2) / (2.0 * 1.0 * 1.0));
    er = $exp(-real'(diff * diff) / (2.0 * 20.0 * 20.0));
    gauss = $rtoi(255.0 * es * er + 0.5);
    if (gauss > 255) gauss = 255;
  endfunction

  function automatic int model(input logic [71:0] w);
    int num = 0, den = 0, c, p, wt, cls, d, q;
    c = int'(w[39:32]);
    for (int k = 0; k < 9; k++) begin
      p   = int'(w[k*8 +: 8]);
      cls = (k == 4) ? 0 : ((k % 2 == 0) ? 2 : 1);
      d   = (p > c) ? p - c : c - p;
      wt  = (k == 4) ? 255 : tab[cls][d];
      num += wt * p;
      den += wt;
    end
    q = (2 * num + den) / (2 * den);
    return (q > 255) ? 255 : q;
  endfunction

  task automatic send(input logic [71:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_win   = w;
    exp_q.push_back(model(w));
    cyc_q.push_back(cyc);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_win   = 72'(({$urandom, $urandom, $urandom}));
    end
  endtask

  task automatic twrite(input int cls, input int d, input int val);
    @(negedge clk);
    tbl_we    = 1'b1;
    tbl_waddr = {2'(cls), 8'(d)};
    tbl_wdata = 8'(val);
    if (cls == 1 || cls == 2) tab[cls][d] = val;
  endtask

  task automatic twrite_end;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  function automatic logic [71:0] flat(input int v);
    for (int k = 0; k < 9; k++) flat[k*8 +: 8] = 8'(v);
  endfunction

  function automatic logic [71:0] rnd_win(input int mode);
    int c = $urandom_range(0, 255);
    for (int k = 0; k < 9; k++) begin
      case (mode)
        0: rnd_win[k*8 +: 8] = 8'($urandom_range(0, 255));
        1: rnd_win[k*8 +: 8] = 8'(c + $urandom_range(0, 24) - 12);
        2: rnd_win[k*8 +: 8] = (k % 3 == 0) ? 8'($urandom_range(0, 30)) : 8'($urandom_range(220, 255));
        default: rnd_win[k*8 +: 8] = $urandom_range(0, 1) ? 8'd255 : 8'd0;
      endcase
    end
  endfunction

  // result monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        if (exp_q.size() == 0) check("R1 unexpected output", 1, 0);
        else begin
          check(tag, int'(out_pix), exp_q.pop_front());
          check("R1 latency", cyc - cyc_q.pop_front(), 13);
        end
        last_out = int'(out_pix);
      end else if (int'(out_pix) != last_out) begin
        check("R8 hold", int'(out_pix), last_out);
      end
    end
  end

  initial begin
    void'($urandom(32'd20240319));
    for (int c = 0; c < 3; c++)
      for (int d = 0; d < 256; d++)
        tab[c][d] = (c == 0) ? 255 : gauss(c, d);

    repeat (3) @(negedge clk);
    check("R8 reset valid", int'(out_valid), 0);
    check("R8 reset pix", int'(out_pix), 0);
    rst = 1'b0;

    // flat windows, default tables
    tag = "R7 flat";
    send(flat(0)); send(flat(255)); send(flat(77));
    idle(16);

    // default tables, varied patterns, back to back
    tag = "R2 R4 R6";
    for (int i = 0; i < 160; i++) send(rnd_win(i % 4));
    idle(16);

    // custom tables through the write port
    tag = "R5 R2 R4";
    for (int d = 0; d < 256; d++) begin
      twrite(1, d, $urandom_range(0, 255));
      twrite(2, d, $urandom_range(0, 255));
    end
    twrite_end();
    for (int i = 0; i < 120; i++) begin
      send(rnd_win(i % 4));
      if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
    end
    idle(16);

    // zero outer weights, then try to hit centre and unused class
    tag = "R9 R3";
    for (int d = 0; d < 256; d++) begin
      twrite(1, d, 0);
      twrite(2, d, 0);
    end
    twrite(0, 0, 0);
    twrite(3, 0, 0);
    twrite(0, 128, 0);
    twrite_end();
    for (int i = 0; i < 40; i++) send(rnd_win(i % 4));
    send(flat(255));
    idle(16);

    // corner weights full, edge zero: check class split
    tag = "R4 R5";
    for (int d = 0; d < 256; d++) twrite(2, d, 255);
    twrite_end();
    send({8'd200, 8'd9, 8'd200, 8'd9, 8'd50, 8'd9, 8'd200, 8'd9, 8'd200});
    for (int i = 0; i < 30; i++) send(rnd_win(0));
    idle(16);

    check("R1 drained", exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      bad++;
      $display("FAIL watchdog got=%0d exp=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule